// File: doc/BRIEF.md
# JTAG-to-SPI Flash Bridge

This block lets a host reach a serial flash through a test access port, with no local clock and no processor. It holds a complete 16-state TAP controller stepped by TMS on rising TCK edges, an instruction register, and a small bypass data register. When the instruction register holds the bridge instruction and the TAP sits in Shift-DR, the block selects the flash and ties the JTAG data path to it. TDI drives MOSI, TCK is the serial clock, and MISO returns on TDO.

Every data-register scan under the bridge instruction becomes exactly one flash transaction. Chip select falls when the TAP enters Shift-DR and rises again when it leaves for Exit1-DR or Pause-DR, so the host frames each flash command, address and data burst by the length of its DR scan. Under any other instruction, Shift-DR passes TDI through a bypass register whose length is a parameter. The bridge code is also a parameter, 0x02 by default.

Top module: `jtag_flash_bridge`

## Requirements
- R1: While trst_n is low the outputs are spi_cs_n=1, tdo=0 and tdo_oe=0, the TAP is held in Test-Logic-Reset, and the instruction register is set to all ones (bypass).
- R2: Five consecutive rising TCK edges with TMS high reach Test-Logic-Reset from any state, which restores the bypass instruction, so a DR scan that follows leaves spi_cs_n high.
- R3: Capture-IR loads 6'b000001. The first six Shift-IR cycles present 1,0,0,0,0,0 on tdo.
- R4: The instruction register shifts TDI in at its most significant end, so the first bit shifted becomes bit 0. The new code takes effect at Update-IR. Shifting the bit-reversed code 0x10 does not select the bridge.
- R5: spi_cs_n is low exactly when the instruction is the bridge code (default 0x02) and the TAP is in Shift-DR. It is high in Exit1-DR, in Pause-DR and in every other state.
- R6: spi_sck always equals tck, and spi_mosi always equals tdi.
- R7: While the bridge is shifting, tdo takes the value of spi_miso at each falling TCK edge.
- R8: Under any other instruction, Shift-DR goes through a DR_LEN-bit bypass register that captures 0 in Capture-DR. tdo then shows tdi delayed by DR_LEN shift cycles.
- R9: tdo and tdo_oe change only on falling TCK edges. tdo_oe is 1 only during Shift-IR and Shift-DR, and tdo is 0 whenever tdo_oe is 0.
- R10: A bridge DR scan with N shift cycles gives exactly N rising TCK edges during which spi_cs_n is low. A pause in the scan does not add or drop an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; also used as the flash serial clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| tdo | output | 1 | Test data out, updated on falling TCK |
| tdo_oe | output | 1 | High while tdo carries shift data |
| spi_sck | output | 1 | Flash serial clock |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Flash serial data in |
| spi_miso | input | 1 | Flash serial data out |

## Verification
The hardest case to reach is a bridge scan that is interrupted, where the TAP passes through Exit1-DR, stays in Pause-DR and returns through Exit2-DR. Chip select must rise for the pause and fall again without losing or adding a clocked bit. The stimulus drives a bridge scan that takes this detour in the middle and counts the chip-select-low cycles against the number of shift cycles. A second hard case is the TMS-high escape straight out of Shift-DR. The bench loads the bridge code, starts a scan and then holds TMS high for five edges. It then shows that a fresh DR scan stays in bypass with the flash deselected.

// File: rtl/jfb_pkg.sv
package jfb_pkg;

   typedef enum logic [3:0] {
      ST_RESET, ST_IDLE,
      ST_SEL_DR, ST_CAP_DR, ST_SHIFT_DR, ST_EXIT1_DR, ST_PAUSE_DR, ST_EXIT2_DR, ST_UPD_DR,
      ST_SEL_IR, ST_CAP_IR, ST_SHIFT_IR, ST_EXIT1_IR, ST_PAUSE_IR, ST_EXIT2_IR, ST_UPD_IR
   } tap_state_t;

   function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
      tap_state_t n;
      case (s)
         ST_RESET:    n = m ? ST_RESET    : ST_IDLE;
         ST_IDLE:     n = m ? ST_SEL_DR   : ST_IDLE;
         ST_SEL_DR:   n = m ? ST_SEL_IR   : ST_CAP_DR;
         ST_CAP_DR:   n = m ? ST_EXIT1_DR : ST_SHIFT_DR;
         ST_SHIFT_DR: n = m ? ST_EXIT1_DR : ST_SHIFT_DR;
         ST_EXIT1_DR: n = m ? ST_UPD_DR   : ST_PAUSE_DR;
         ST_PAUSE_DR: n = m ? ST_EXIT2_DR : ST_PAUSE_DR;
         ST_EXIT2_DR: n = m ? ST_UPD_DR   : ST_SHIFT_DR;
         ST_UPD_DR:   n = m ? ST_SEL_DR   : ST_IDLE;
         ST_SEL_IR:   n = m ? ST_RESET    : ST_CAP_IR;
         ST_CAP_IR:   n = m ? ST_EXIT1_IR : ST_SHIFT_IR;
         ST_SHIFT_IR: n = m ? ST_EXIT1_IR : ST_SHIFT_IR;
         ST_EXIT1_IR: n = m ? ST_UPD_IR   : ST_PAUSE_IR;
         ST_PAUSE_IR: n = m ? ST_EXIT2_IR : ST_PAUSE_IR;
         ST_EXIT2_IR: n = m ? ST_UPD_IR   : ST_SHIFT_IR;
         default:     n = m ? ST_SEL_DR   : ST_IDLE;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/jfb_tap.sv
module jfb_tap
   import jfb_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_t state
);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= ST_RESET;
      else         state <= tap_next(state, tms);
   end

   // run length of TMS-high edges, saturating at five, for the escape check
   logic [2:0] hi_run;
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)          hi_run <= 3'd0;
      else if (!tms)        hi_run <= 3'd0;
      else if (hi_run != 3'd5) hi_run <= hi_run + 3'd1;
   end

   a_r2_five_high_resets: assert property (@(posedge tck) disable iff (!trst_n)
      (hi_run == 3'd5) |-> (state == ST_RESET));

endmodule

// File: rtl/jfb_ir.sv
module jfb_ir
   import jfb_pkg::*;
#(
   parameter int unsigned IR_W = 6
) (
   input  logic            tck,
   input  logic            trst_n,
   input  tap_state_t      state,
   input  logic            tdi,
   output logic [IR_W-1:0] ir_q,
   output logic            ir_lsb
);

   localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-1){1'b0}}, 1'b1};
   localparam logic [IR_W-1:0] IR_BYPASS  = {IR_W{1'b1}};

   logic [IR_W-1:0] ir_sh;

   always_ff @(posedge tck) begin
      if (state == ST_CAP_IR)        ir_sh <= IR_CAPTURE;
      else if (state == ST_SHIFT_IR) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
   end

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n)                 ir_q <= IR_BYPASS;
      else if (state == ST_RESET)  ir_q <= IR_BYPASS;
      else if (state == ST_UPD_IR) ir_q <= ir_sh;
   end

   assign ir_lsb = ir_sh[0];

   a_r3_capture_pattern: assert property (@(posedge tck) disable iff (!trst_n)
      ($past(state) == ST_CAP_IR) |-> (ir_sh == IR_CAPTURE));

   a_r1_reset_gives_bypass: assert property (@(negedge tck) disable iff (!trst_n)
      (state == ST_RESET) |=> (ir_q == IR_BYPASS));

endmodule

// File: rtl/jfb_dr.sv
module jfb_dr
   import jfb_pkg::*;
#(
   parameter int unsigned DR_LEN = 1
) (
   input  logic       tck,
   input  logic       trst_n,
   input  tap_state_t state,
   input  logic       tdi,
   output logic       dr_out
);

   generate
      if (DR_LEN == 1) begin : g_single
         logic q;
         always_ff @(posedge tck) begin
            if (state == ST_CAP_DR)        q <= 1'b0;
            else if (state == ST_SHIFT_DR) q <= tdi;
         end
         assign dr_out = q;
      end else begin : g_chain
         logic [DR_LEN-1:0] q;
         always_ff @(posedge tck) begin
            if (state == ST_CAP_DR)        q <= '0;
            else if (state == ST_SHIFT_DR) q <= {tdi, q[DR_LEN-1:1]};
         end
         assign dr_out = q[0];
      end
   endgenerate

   a_r8_capture_zero: assert property (@(posedge tck) disable iff (!trst_n)
      ($past(state) == ST_CAP_DR) |-> (dr_out == 1'b0));

endmodule

// File: rtl/jtag_flash_bridge.sv
module jtag_flash_bridge
   import jfb_pkg::*;
#(
   parameter int unsigned IR_W        = 6,
   parameter int unsigned BRIDGE_CODE = 2,
   parameter int unsigned DR_LEN      = 1
) (
   input  logic tck,
   input  logic trst_n,
   input  logic tms,
   input  logic tdi,
   output logic tdo,
   output logic tdo_oe,
   output logic spi_sck,
   output logic spi_cs_n,
   output logic spi_mosi,
   input  logic spi_miso
);

   localparam logic [IR_W-1:0] SEL_CODE = BRIDGE_CODE[IR_W-1:0];

   generate
      if (IR_W < 2 || IR_W > 16) begin : g_bad_irw
         $error("IR_W must lie in 2..16");
      end
      if (DR_LEN < 1 || DR_LEN > 64) begin : g_bad_drlen
         $error("DR_LEN must lie in 1..64");
      end
      if (BRIDGE_CODE >= (1 << IR_W) - 1) begin : g_bad_code
         $error("BRIDGE_CODE must fit IR_W and differ from the bypass code");
      end
   endgenerate

   tap_state_t      state;
   logic [IR_W-1:0] ir_q;
   logic            ir_lsb;
   logic            dr_out;
   logic            bridge_sel;
   logic            bridge_on;

   jfb_tap u_tap (.tck(tck), .trst_n(trst_n), .tms(tms), .state(state));

   jfb_ir #(.IR_W(IR_W)) u_ir (
      .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
      .ir_q(ir_q), .ir_lsb(ir_lsb));

   jfb_dr #(.DR_LEN(DR_LEN)) u_dr (
      .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi), .dr_out(dr_out));

   assign bridge_sel = (ir_q == SEL_CODE);
   assign bridge_on  = bridge_sel && (state == ST_SHIFT_DR);

   assign spi_cs_n = !bridge_on;
   assign spi_sck  = tck;
   assign spi_mosi = tdi;

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo    <= 1'b0;
         tdo_oe <= 1'b0;
      end else begin
         case (state)
            ST_SHIFT_IR: begin
               tdo    <= ir_lsb;
               tdo_oe <= 1'b1;
            end
            ST_SHIFT_DR: begin
               tdo    <= bridge_sel ? spi_miso : dr_out;
               tdo_oe <= 1'b1;
            end
            default: begin
               tdo    <= 1'b0;
               tdo_oe <= 1'b0;
            end
         endcase
      end
   end

   a_r5_deselect_off_shift: assert property (@(posedge tck) disable iff (!trst_n)
      (state != ST_SHIFT_DR) |-> spi_cs_n);

   a_r7_miso_to_tdo: assert property (@(negedge tck) disable iff (!trst_n)
      (bridge_sel && state == ST_SHIFT_DR) |=> (tdo == $past(spi_miso)));

   a_r9_quiet_tdo: assert property (@(posedge tck) disable iff (!trst_n)
      !tdo_oe |-> (tdo == 1'b0));

   a_r9_oe_steady_at_rise: assert property (@(negedge tck) disable iff (!trst_n)
      (state != ST_SHIFT_IR && state != ST_SHIFT_DR) |=> !tdo_oe);

endmodule

// File: tb/sim_jtag_flash_bridge.sv
module sim_jtag_flash_bridge;

   localparam int IRW = 6;
   localparam int DRL = 1;
   localparam logic [IRW-1:0] BRIDGE = 6'h02;

   logic tck = 1'b0;
   logic trst_n = 1'b0;
   logic tms = 1'b1;
   logic tdi = 1'b0;
   logic spi_miso = 1'b0;
   logic tdo, tdo_oe, spi_sck, spi_cs_n, spi_mosi;

   always #4 tck = ~tck;   // 125 MHz

   jtag_flash_bridge #(.IR_W(IRW), .BRIDGE_CODE(2), .DR_LEN(DRL)) u0 (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
      .tdo(tdo), .tdo_oe(tdo_oe), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso));

   typedef struct {
      logic  tdo;
      logic  oe;
      logic  cs_n;
      logic  tdi;
      string req;
   } exp_t;

   exp_t q[$];
   int total = 0;
   int bad = 0;
   int cs_low = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // monitor: one item per TCK cycle, sampled 1 ns before the rising edge
   initial begin
      forever begin
         @(negedge tck);
         #3;
         if (!spi_cs_n) cs_low++;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(tdo == e.tdo, e.req, "tdo", int'(tdo), int'(e.tdo));
            check(tdo_oe == e.oe, (e.req == "R9") ? "R9" : {e.req, "/R9"}, "tdo_oe",
                  int'(tdo_oe), int'(e.oe));
            check(spi_cs_n == e.cs_n, (e.cs_n ? e.req : "R5"), "spi_cs_n",
                  int'(spi_cs_n), int'(e.cs_n));
            check(spi_mosi == e.tdi && spi_sck == tck, "R6", "mosi/sck",
                  int'({spi_mosi, spi_sck}), int'({e.tdi, tck}));
         end
      end
   end

   // driver: one TCK cycle per call
   task automatic tick(input logic tms_v, input logic tdi_v, input logic miso_v,
                       input logic exp_tdo, input logic exp_oe, input logic exp_cs,
                       input string req);
      exp_t e;
      @(posedge tck);
      #1 spi_miso = miso_v;
      @(negedge tck);
      #1;
      tms = tms_v;
      tdi = tdi_v;
      e.tdo = exp_tdo; e.oe = exp_oe; e.cs_n = exp_cs; e.tdi = tdi_v; e.req = req;
      q.push_back(e);
   endtask

   task automatic idle(input logic tms_v, input string req);
      tick(tms_v, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, req);
   endtask

   // from Run-Test/Idle back to Run-Test/Idle
   task automatic ir_scan(input logic [IRW-1:0] code);
      idle(1'b1, "R9");
      idle(1'b1, "R9");
      idle(1'b0, "R9");
      idle(1'b0, "R9");
      for (int i = 0; i < IRW; i++)
         tick(i == IRW - 1, code[i], 1'b0, i == 0, 1'b1, 1'b1, "R3");
      idle(1'b1, "R9");
      idle(1'b0, "R4");
   endtask

   // from Run-Test/Idle back to Run-Test/Idle; optional pause after bit pz
   task automatic dr_scan(input int n, input logic [63:0] d, input logic [63:0] m,
                          input bit bridge, input int pz, input string req);
      idle(1'b1, "R9");
      idle(1'b0, "R9");
      idle(1'b0, "R9");
      for (int i = 0; i < n; i++) begin
         logic et;
         et = bridge ? m[i] : ((i < DRL) ? 1'b0 : d[i-DRL]);
         tick((i == n - 1) || (i == pz), d[i], m[i], et, 1'b1, !bridge, req);
         if (i == pz && i != n - 1) begin
            idle(1'b0, "R5");   // Exit1-DR
            idle(1'b0, "R5");   // Pause-DR
            idle(1'b1, "R5");   // Pause-DR
            idle(1'b0, "R5");   // Exit2-DR
         end
      end
      idle(1'b1, "R9");
      idle(1'b0, "R9");
   endtask

   task automatic count_check(input int n, input string req);
      idle(1'b0, "R9");
      idle(1'b0, "R9");
      #6;
      check(cs_low == n, req, "cs_low_cycles", cs_low, n);
   endtask

   initial begin
      repeat (100000) @(posedge tck);
      total++;
      bad++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge tck);
      #2;
      check(spi_cs_n == 1'b1, "R1", "spi_cs_n", int'(spi_cs_n), 1);
      check(tdo == 1'b0, "R1", "tdo", int'(tdo), 0);
      check(tdo_oe == 1'b0, "R1", "tdo_oe", int'(tdo_oe), 0);
      @(negedge tck);
      #1 trst_n = 1'b1;
      idle(1'b0, "R1");                  // Test-Logic-Reset -> Idle
      // R1: instruction after reset is bypass
      dr_scan(4, 64'hA, 64'h0, 1'b0, -1, "R1");

      // R3, R7, R10: bridge scan
      ir_scan(BRIDGE);
      cs_low = 0;
      dr_scan(8, 64'h9C, 64'h5B, 1'b1, -1, "R7");
      count_check(8, "R10");

      // R5, R10: bridge scan with a pause in the middle
      cs_low = 0;
      dr_scan(10, 64'h2F1, 64'h1C6, 1'b1, 4, "R5");
      count_check(10, "R10");

      // R4: bit-reversed code must not select the bridge
      ir_scan(6'h10);
      cs_low = 0;
      dr_scan(6, 64'h2D, 64'h3F, 1'b0, -1, "R4");
      count_check(0, "R4");

      // R8: other instruction, bypass delay
      ir_scan(6'h05);
      dr_scan(9, 64'h1B3, 64'h0, 1'b0, 3, "R8");

      // R2: escape from Shift-DR by five TMS-high edges
      ir_scan(BRIDGE);
      idle(1'b1, "R9");
      idle(1'b0, "R9");
      idle(1'b0, "R9");
      tick(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R2");   // in Shift-DR
      idle(1'b1, "R2");
      idle(1'b1, "R2");
      idle(1'b1, "R2");
      idle(1'b1, "R2");
      idle(1'b0, "R2");                                 // Test-Logic-Reset
      cs_low = 0;
      dr_scan(5, 64'h15, 64'h1F, 1'b0, -1, "R2");
      count_check(0, "R2");

      repeat (2) @(posedge tck);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule